// File: doc/BRIEF.md
# Tone-Gated Byte Encoder for Satellite Switch Control

This block sends one 8-bit control byte to a satellite switch or LNB as a gate for an external 22 kHz oscillator. It does not make the carrier itself. It drives a single enable line that the board uses to switch the tone on and off. Each byte goes out as nine symbols: the eight data bits, most significant first, followed by an odd-parity bit. Each symbol is coded by how long the tone lasts.

All timing comes from an external periodic strobe of about 500 us, one clock cycle wide. Each symbol takes three strobe intervals. The first interval is silent. The tone then runs for two intervals for a 0, or for one interval for a 1. The gate is always low again once the third interval ends, so a byte takes 27 strobe intervals, about 13.5 ms. The block holds one pending-strobe flag, which remembers a strobe that arrives while it is idle. A first-byte flag given with the start strobe clears that pending strobe, so timing starts from a fresh strobe. Without the flag, a strobe that is already pending counts as the end of the first silent interval. Message framing and the strobe source are outside this block.

Top module: `tone_byte_encoder`

## Requirements
- R1: After reset, gate_o, busy_o and done_o are all low.
- R2: A start_i pulse while idle latches data_i and raises busy_o on the next cycle. A start_i pulse while busy_o is high changes neither the byte being sent nor the timing.
- R3: Each symbol spans three strobe events. The gate stays low until the first event, then is high from the cycle after that event. The gate never changes except on the cycle after a strobe event.
- R4: For a data bit of 0, the gate stays high across the second event and goes low on the cycle after the third event.
- R5: For a data bit of 1, the gate goes low on the cycle after the second event and stays low through the third.
- R6: The data bits go out most significant bit (data_i[7]) first.
- R7: A ninth symbol follows the data. Its bit value is 1 when the byte holds an even number of ones and 0 otherwise, so the nine bits together have odd parity.
- R8: With first_i high at start, a strobe that arrived while idle or in the start cycle is discarded. With first_i low, such a strobe is kept and ends the first silent interval on the cycle after start.
- R9: done_o is high for exactly one cycle, the cycle after the 27th strobe event. busy_o falls in that same cycle.
- R10: The gate is low whenever busy_o is low, and strobes while idle never raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Periodic timing strobe, about 500 us apart |
| start_i | input | 1 | Begin sending data_i |
| first_i | input | 1 | Discard any pending strobe at start |
| data_i | input | 8 | Byte to send |
| gate_o | output | 1 | Registered carrier enable |
| busy_o | output | 1 | Byte in progress |
| done_o | output | 1 | One-cycle pulse when the byte has finished |

## Verification
The assertions check four properties on every cycle. The gate stays low while idle. The gate moves only after a strobe event. done_o lasts one cycle and coincides with busy_o falling. A start while busy leaves the latched byte and the symbol count untouched; a start with the first-byte flag leaves no pending strobe. Only the bench scenarios can show the symbol shapes for 0 and 1 bits, the MSB-first order, the parity value for even and odd counts of ones, and the two start modes. The bench checks these by recording the gate after every strobe and comparing it with a per-cycle reference model.

// File: rtl/tone_byte_encoder.sv
module tone_byte_encoder #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              gate_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int NSYM = DATA_W + 1;
  localparam int CW   = $clog2(NSYM + 1);

  logic            busy_q, done_q, gate_q, pend_q;
  logic [1:0]      phase_q;
  logic [CW-1:0]   sym_q;
  logic [NSYM-1:0] sh_q;

  wire ev   = busy_q & (tick_i | pend_q);
  wire cur  = sh_q[NSYM-1];
  wire last = (sym_q == CW'(NSYM - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      gate_q  <= 1'b0;
      pend_q  <= 1'b0;
      phase_q <= 2'd0;
      sym_q   <= '0;
      sh_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        pend_q <= (start_i & first_i) ? 1'b0 : (pend_q | tick_i);
        if (start_i) begin
          busy_q  <= 1'b1;
          sh_q    <= {data_i, ~^data_i};
          sym_q   <= '0;
          phase_q <= 2'd0;
        end
      end else begin
        pend_q <= 1'b0;
        if (ev) begin
          case (phase_q)
            2'd0: begin
              gate_q  <= 1'b1;
              phase_q <= 2'd1;
            end
            2'd1: begin
              gate_q  <= gate_q & ~cur;
              phase_q <= 2'd2;
            end
            default: begin
              gate_q  <= 1'b0;
              phase_q <= 2'd0;
              if (last) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end else begin
                sym_q <= sym_q + CW'(1);
                sh_q  <= sh_q << 1;
              end
            end
          endcase
        end
      end
    end
  end

  assign gate_o = gate_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  assert_idle_gate_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !gate_o);

  assert_gate_moves_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o != $past(gate_o)) |-> $past(tick_i || pend_q));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_with_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $fell(busy_o));

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && !tick_i && !pend_q) |=> ($stable(sh_q) && $stable(sym_q)));

  assert_first_discards_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start_i && first_i) |=> !pend_q);
endmodule

// File: tb/tone_byte_encoder_test.sv
`timescale 1ns/1ps
module tone_byte_encoder_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_i = 1'b0, start_i = 1'b0, first_i = 1'b0;
  logic [7:0] data_i = '0;
  logic gate_o, busy_o, done_o;

  always #2.5 clk = ~clk;

  tone_byte_encoder uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_i(start_i),
    .first_i(first_i), .data_i(data_i),
    .gate_o(gate_o), .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit cap[$];
  bit mq[$];
  bit mbusy = 0, mpend = 0, mgate = 0, mdone = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic bit exp_level(input logic [7:0] d, input int k);
    int s = k / 3;
    int p = k % 3;
    bit b = (s < 8) ? d[7 - s] : ~^d;
    if (p == 0) return 1'b1;
    if (p == 1) return !b;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 0; mpend = 0; mgate = 0; mdone = 0;
      mq.delete();
    end else begin
      mdone = 0;
      if (mbusy) begin
        if (tick_i || mpend) begin
          mgate = mq.pop_front();
          if (mq.size() == 0) begin
            mbusy = 0;
            mdone = 1;
          end
        end
        mpend = 0;
      end else if (start_i) begin
        for (int k = 0; k < 27; k++) mq.push_back(exp_level(data_i, k));
        mbusy = 1;
        mpend = first_i ? 1'b0 : (mpend | tick_i);
      end else begin
        mpend = mpend | tick_i;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(gate_o == mgate, "R4 model gate", gate_o, mgate);
      chk(busy_o == mbusy, "R2 model busy", busy_o, mbusy);
      chk(done_o == mdone, "R9 model done", done_o, mdone);
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic pulse();
    repeat (3) @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    cap.push_back(gate_o);
  endtask

  task automatic idle_tick();
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic start(input logic [7:0] d, input bit f, input bit t);
    @(negedge clk);
    data_i = d; first_i = f; start_i = 1'b1; tick_i = t;
    @(negedge clk);
    start_i = 1'b0; tick_i = 1'b0;
    cap.delete();
  endtask

  task automatic pattern(input logic [7:0] d, input string tag);
    for (int k = 0; k < cap.size(); k++)
      chk(cap[k] == exp_level(d, k), tag, cap[k], exp_level(d, k));
  endtask

  task automatic finish_byte();
    chk(done_o == 1'b1, "R9 done after last tick", done_o, 1);
    chk(busy_o == 1'b0, "R9 busy falls with done", busy_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R9 done one cycle", done_o, 0);
    chk(gate_o == 1'b0, "R10 gate low when idle", gate_o, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(gate_o == 1'b0, "R1 gate reset", gate_o, 0);
    chk(busy_o == 1'b0, "R1 busy reset", busy_o, 0);
    chk(done_o == 1'b0, "R1 done reset", done_o, 0);
    rst_n = 1'b1;

    start(8'h00, 1'b1, 1'b0);
    chk(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
    repeat (5) @(negedge clk);
    chk(gate_o == 1'b0, "R3 silent before first tick", gate_o, 0);
    repeat (27) pulse();
    chk(cap[0] == 1'b1, "R3 gate up after first tick", cap[0], 1);
    chk(cap[1] == 1'b1, "R4 zero keeps tone", cap[1], 1);
    chk(cap[2] == 1'b0, "R4 zero ends at third tick", cap[2], 0);
    pattern(8'h00, "R4 pattern 00");
    finish_byte();

    start(8'hFF, 1'b1, 1'b0);
    repeat (27) pulse();
    chk(cap[1] == 1'b0, "R5 one cuts at second tick", cap[1], 0);
    pattern(8'hFF, "R5 pattern FF");
    finish_byte();

    start(8'h80, 1'b1, 1'b0);
    repeat (27) pulse();
    chk(cap[1] == 1'b0, "R6 msb first", cap[1], 0);
    chk(cap[4] == 1'b1, "R6 second bit zero", cap[4], 1);
    chk(cap[25] == 1'b1, "R7 odd count parity 0", cap[25], 1);
    pattern(8'h80, "R6 pattern 80");
    finish_byte();

    start(8'h03, 1'b1, 1'b0);
    repeat (27) pulse();
    chk(cap[25] == 1'b0, "R7 even count parity 1", cap[25], 0);
    pattern(8'h03, "R7 pattern 03");
    finish_byte();

    idle_tick();
    start(8'h55, 1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk(gate_o == 1'b0, "R8 pending tick discarded", gate_o, 0);
    repeat (27) pulse();
    pattern(8'h55, "R8 pattern 55");
    finish_byte();

    idle_tick();
    start(8'h00, 1'b0, 1'b0);
    @(negedge clk);
    chk(gate_o == 1'b1, "R8 pending tick kept", gate_o, 1);
    repeat (26) pulse();
    chk(cap[0] == 1'b1, "R8 kept tick second event", cap[0], 1);
    finish_byte();

    start(8'h0F, 1'b1, 1'b0);
    repeat (10) pulse();
    @(negedge clk);
    data_i = 8'hF0; first_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 still busy", busy_o, 1);
    repeat (17) pulse();
    pattern(8'h0F, "R2 start ignored");
    finish_byte();

    idle_tick();
    idle_tick();
    @(negedge clk);
    chk(gate_o == 1'b0, "R10 idle tick no gate", gate_o, 0);
    chk(busy_o == 1'b0, "R10 idle tick no busy", busy_o, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule